// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer with Two Pointers

This block produces the row addresses for a rolling-shutter pixel array. A read pointer steps once through a window of rows on every line period. A second pointer, trailing the first, marks rows for reset. The distance between the two pointers, counted in line periods, sets how long each row integrates light. A line-advance strobe from the line timer paces the whole sequence. A frame lasts `cfg_nlines + 1` line periods. The window begins at a row chosen from a list of start positions.

Two non-destructive readout variants reuse the same pointers. In the first, rows are reset only in every other frame and read in every frame. In the second, the trailing pointer also reads, and the leading pointer reads only in even frames, so each row is sampled twice per two-frame cycle at two alternating spacings. A one-bit frame phase, cleared by reset and inverted at each frame start, picks the even and odd frames. Each line produces end-of-line, end-of-frame and pixel-valid pulses. Each has its own clock delay, so downstream sampling can be lined up with converter latency. All settings are captured at frame start.

Top module: `rsh_row_seq`

## Requirements
- R1: A line begins on each clock where `line_adv` is sampled high. The first line after reset, and the line after the frame's last line (index N = captured `cfg_nlines`), has index 0. Any other line has the previous index + 1. Two clocks after `line_adv` is sampled, `rd_stb` is high for one clock with `rd_row` = window base + line index. This holds in every mode except R5's odd frames.
- R2: Mode select: `cfg_ndr_en`=0 is standard mode; `cfg_ndr_en`=1 with `cfg_ndr_md`=0 is readout mode A; `cfg_ndr_en`=1 with `cfg_ndr_md`=1 is readout mode B. In standard mode `rst_stb` fires on every line. Each row's read comes N − T + 1 lines after its most recent reset, where T is the captured integration setting.
- R3: An integration setting above `cfg_nlines` is treated as equal to `cfg_nlines`.
- R4: In readout mode A, consecutive reads of one row are N + 1 lines apart. `rst_stb` fires only in frames with phase 0. The phase is 0 in the first frame after reset and inverts at each later frame start.
- R5: In readout mode B, `rd_stb` stays low in phase-1 frames, and the `rst_row`/`rst_stb` pointer acts as a second read. The spacing between reads of a row alternates between 2T + 1 and 2(N + 1) − (2T + 1).
- R6: Window start position p, clamped to 137, maps to row p for p ≤ 12 and to row 14 + 24·(p − 13) for p ≥ 13.
- R7: `cfg_nlines`, `cfg_int`, mode, `cfg_wpos` and `cfg_dly` are captured only when a frame begins. Changes made mid-frame leave the rest of that frame unchanged.
- R8: `eol` pulses once per line, `cfg_dly[7:4]` clocks after the cycle in which R1's read strobe would be high. `eof` pulses with the same delay, on line N only.
- R9: `pix_vld` pulses once per line, `cfg_dly[3:0]` clocks after that same cycle.
- R10: Reset holds every strobe and pulse output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_adv | input | 1 | One-clock strobe that starts a line period |
| cfg_nlines | input | CNT_W | Last line index of the frame |
| cfg_int | input | CNT_W | Integration setting T |
| cfg_ndr_en | input | 1 | Non-destructive readout enable |
| cfg_ndr_md | input | 1 | Readout variant select (0: A, 1: B) |
| cfg_wpos | input | POS_W | Window start position |
| cfg_dly | input | 2*DLY_W | [3:0] pixel-valid delay, [7:4] line/frame delay |
| rst_row | output | ROW_W | Trailing pointer row address |
| rst_stb | output | 1 | Trailing pointer strobe |
| rd_row | output | ROW_W | Read pointer row address |
| rd_stb | output | 1 | Read pointer strobe |
| eol | output | 1 | Delayed end-of-line pulse |
| eof | output | 1 | Delayed end-of-frame pulse |
| pix_vld | output | 1 | Delayed pixel-valid pulse |

## Verification
Two things can land in the same line. In standard mode with T = 0, the reset and the read of one row happen together. In readout mode B, both pointers can read in one line. The bench sweeps every small combination of N, T and mode, which brings up both cases. It judges them by tracking each row's last reset and last read in absolute line numbers. For the same-line case, the read is judged against the earlier reset before the reset seen in that line is recorded. A wrong pointer offset therefore shows up as a wrong interval, not as a missing strobe.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

  typedef enum logic [1:0] {
    MD_STD  = 2'd0,
    MD_NDR1 = 2'd1,
    MD_NDR2 = 2'd2
  } rsh_mode_e;

  // integration setting limited to the last line index
  function automatic int clamp_int(input int t, input int n);
    return (t > n) ? n : t;
  endfunction

  // trailing pointer index for standard and variant A, m = lines per frame
  function automatic int std_left(input int l, input int t, input int m);
    return (l >= t) ? (l - t) : (l + m - t);
  endfunction

  // variant B: a = line within two-frame cycle, k = lag; -1 when idle
  function automatic int md2_left(input int a, input int k, input int m);
    int v;
    v = a + 2 * m - k;
    if (v >= 2 * m) v = v - 2 * m;
    return (v < m) ? v : -1;
  endfunction

  // window start position to physical row
  function automatic int win_row(input int pos, input int ndum, input int nxtra,
                                 input int blk, input int nact);
    int npos;
    int p;
    npos = ndum + 1 + nact / blk;
    p    = (pos > npos - 1) ? (npos - 1) : pos;
    if (p <= ndum) return p;
    return ndum + nxtra + blk * (p - ndum - 1);
  endfunction

endpackage

// File: rtl/rsh_line_ctl.sv
module rsh_line_ctl
  import rsh_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ROW_W = 12,
  parameter int POS_W = 8,
  parameter int DLY_W = 4,
  parameter int NDUM  = 12,
  parameter int NXTRA = 2,
  parameter int NACT  = 3000,
  parameter int BLK   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_adv,
  input  logic [CNT_W-1:0] cfg_nlines,
  input  logic [CNT_W-1:0] cfg_int,
  input  logic             cfg_ndr_en,
  input  logic             cfg_ndr_md,
  input  logic [POS_W-1:0] cfg_wpos,
  input  logic [2*DLY_W-1:0] cfg_dly,
  output logic             go_q,
  output logic [CNT_W-1:0] line_q,
  output logic             phase_q,
  output logic [CNT_W-1:0] n_q,
  output logic [CNT_W-1:0] t_q,
  output rsh_mode_e        mode_q,
  output logic [ROW_W-1:0] base_q,
  output logic [DLY_W-1:0] dpv_q,
  output logic [DLY_W-1:0] deo_q,
  output logic             frm_wrap
);

  logic running_q;
  rsh_mode_e mode_in;

  // frame starts on the first line after reset or after line N
  assign frm_wrap = line_adv & (~running_q | (line_q == n_q));

  always_comb begin
    if (!cfg_ndr_en)     mode_in = MD_STD;
    else if (cfg_ndr_md) mode_in = MD_NDR2;
    else                 mode_in = MD_NDR1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q      <= 1'b0;
      line_q    <= '0;
      phase_q   <= 1'b0;
      running_q <= 1'b0;
      n_q       <= '0;
      t_q       <= '0;
      mode_q    <= MD_STD;
      base_q    <= '0;
      dpv_q     <= '0;
      deo_q     <= '0;
    end else begin
      go_q <= line_adv;
      if (frm_wrap) begin
        line_q    <= '0;
        phase_q   <= running_q ? ~phase_q : 1'b0;
        running_q <= 1'b1;
        n_q       <= cfg_nlines;
        t_q       <= CNT_W'(clamp_int(int'(cfg_int), int'(cfg_nlines)));
        mode_q    <= mode_in;
        base_q    <= ROW_W'(win_row(int'(cfg_wpos), NDUM, NXTRA, BLK, NACT));
        dpv_q     <= cfg_dly[DLY_W-1:0];
        deo_q     <= cfg_dly[2*DLY_W-1:DLY_W];
      end else if (line_adv) begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (line_q <= n_q)); // R1

  AST_INT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (t_q <= n_q)); // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !frm_wrap) |=> ($stable(n_q) && $stable(t_q) && $stable(base_q) && $stable(mode_q))); // R7

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && frm_wrap) |=> (phase_q != $past(phase_q))); // R4

endmodule

// File: rtl/rsh_ptr_gen.sv
module rsh_ptr_gen
  import rsh_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] line,
  input  logic             phase,
  input  logic [CNT_W-1:0] n,
  input  logic [CNT_W-1:0] t,
  input  rsh_mode_e        mode,
  input  logic [ROW_W-1:0] base,
  output logic [ROW_W-1:0] rd_row,
  output logic             rd_stb,
  output logic [ROW_W-1:0] lf_row,
  output logic             lf_stb,
  output logic             ln_pulse,
  output logic             ln_last
);

  int   m_i;
  int   l_i;
  int   a_i;
  int   lf_i;
  logic rd_ok;
  logic lf_hit;

  always_comb begin
    m_i   = int'(n) + 1;
    l_i   = int'(line);
    a_i   = phase ? (m_i + l_i) : l_i;
    rd_ok = !((mode == MD_NDR2) && phase);
    if (mode == MD_NDR2) lf_i = md2_left(a_i, 2 * int'(t) + 1, m_i);
    else                 lf_i = std_left(l_i, int'(t), m_i);
    lf_hit = (lf_i >= 0) && !((mode == MD_NDR1) && phase);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_row   <= '0;
      rd_stb   <= 1'b0;
      lf_row   <= '0;
      lf_stb   <= 1'b0;
      ln_pulse <= 1'b0;
      ln_last  <= 1'b0;
    end else begin
      rd_stb   <= go & rd_ok;
      lf_stb   <= go & lf_hit;
      ln_pulse <= go;
      ln_last  <= go & (line == n);
      if (go) rd_row <= base + ROW_W'(l_i);
      if (go && lf_hit) lf_row <= base + ROW_W'(lf_i);
    end
  end

  AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (int'(ROW_W'(rd_row - $past(base))) <= int'($past(n)))); // R1

  AST_LF_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    lf_stb |-> (int'(ROW_W'(lf_row - $past(base))) <= int'($past(n)))); // R2

  AST_MD2_ODD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode) == MD_NDR2) && $past(phase)) |-> !rd_stb); // R5

  AST_LAST_IS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ln_last |-> ln_pulse); // R8

endmodule

// File: rtl/rsh_pulse_dly.sv
module rsh_pulse_dly #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [DLY_W-1:0] code,
  output logic             pout
);

  localparam int DEPTH = 1 << DLY_W;

  logic [DEPTH-1:1] sr;
  logic [DEPTH-1:0] taps;

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      if (k == 1) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) sr[k] <= 1'b0;
          else        sr[k] <= pin;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) sr[k] <= 1'b0;
          else        sr[k] <= sr[k-1];
        end
      end
    end
  endgenerate

  assign taps = {sr, pin};
  assign pout = taps[code];

endmodule

// File: rtl/rsh_row_seq.sv
module rsh_row_seq
  import rsh_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ROW_W = 12,
  parameter int DLY_W = 4,
  parameter int NDUM  = 12,
  parameter int NXTRA = 2,
  parameter int NACT  = 3000,
  parameter int BLK   = 24,
  localparam int NPOS = NDUM + 1 + NACT / BLK,
  localparam int POS_W = $clog2(NPOS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_adv,
  input  logic [CNT_W-1:0]   cfg_nlines,
  input  logic [CNT_W-1:0]   cfg_int,
  input  logic               cfg_ndr_en,
  input  logic               cfg_ndr_md,
  input  logic [POS_W-1:0]   cfg_wpos,
  input  logic [2*DLY_W-1:0] cfg_dly,
  output logic [ROW_W-1:0]   rst_row,
  output logic               rst_stb,
  output logic [ROW_W-1:0]   rd_row,
  output logic               rd_stb,
  output logic               eol,
  output logic               eof,
  output logic               pix_vld
);

  logic             go_q;
  logic [CNT_W-1:0] line_q;
  logic             phase_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] t_q;
  rsh_mode_e        mode_q;
  logic [ROW_W-1:0] base_q;
  logic [DLY_W-1:0] dpv_q;
  logic [DLY_W-1:0] deo_q;
  logic             frm_wrap;
  logic             ln_pulse;
  logic             ln_last;

  rsh_line_ctl #(
    .CNT_W(CNT_W), .ROW_W(ROW_W), .POS_W(POS_W), .DLY_W(DLY_W),
    .NDUM(NDUM), .NXTRA(NXTRA), .NACT(NACT), .BLK(BLK)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .line_adv(line_adv),
    .cfg_nlines(cfg_nlines), .cfg_int(cfg_int),
    .cfg_ndr_en(cfg_ndr_en), .cfg_ndr_md(cfg_ndr_md),
    .cfg_wpos(cfg_wpos), .cfg_dly(cfg_dly),
    .go_q(go_q), .line_q(line_q), .phase_q(phase_q), .n_q(n_q), .t_q(t_q),
    .mode_q(mode_q), .base_q(base_q), .dpv_q(dpv_q), .deo_q(deo_q),
    .frm_wrap(frm_wrap)
  );

  rsh_ptr_gen #(.CNT_W(CNT_W), .ROW_W(ROW_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .go(go_q), .line(line_q), .phase(phase_q),
    .n(n_q), .t(t_q), .mode(mode_q), .base(base_q),
    .rd_row(rd_row), .rd_stb(rd_stb), .lf_row(rst_row), .lf_stb(rst_stb),
    .ln_pulse(ln_pulse), .ln_last(ln_last)
  );

  rsh_pulse_dly #(.DLY_W(DLY_W)) u_eol (
    .clk(clk), .rst_n(rst_n), .pin(ln_pulse), .code(deo_q), .pout(eol));

  rsh_pulse_dly #(.DLY_W(DLY_W)) u_eof (
    .clk(clk), .rst_n(rst_n), .pin(ln_last), .code(deo_q), .pout(eof));

  rsh_pulse_dly #(.DLY_W(DLY_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .pin(ln_pulse), .code(dpv_q), .pout(pix_vld));

  AST_RD_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $past(line_adv, 2)); // R1

  AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> eol); // R8

endmodule

// File: tb/sim_rsh_row_seq.sv
module sim_rsh_row_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_adv = 1'b0;
  logic [11:0] cfg_nlines = '0;
  logic [11:0] cfg_int = '0;
  logic        cfg_ndr_en = 1'b0;
  logic        cfg_ndr_md = 1'b0;
  logic [7:0]  cfg_wpos = '0;
  logic [7:0]  cfg_dly = '0;
  logic [11:0] rst_row;
  logic        rst_stb;
  logic [11:0] rd_row;
  logic        rd_stb;
  logic        eol;
  logic        eof;
  logic        pix_vld;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int s_rd_stb, s_rd_row, s_rst_stb, s_rst_row, k_eol, k_eof, k_pix;
  int last_rst[0:7];
  int last_rd[0:7];
  int prev_iv[0:7];

  always #5 clk = ~clk;

  rsh_row_seq u0 (
    .clk(clk), .rst_n(rst_n), .line_adv(line_adv),
    .cfg_nlines(cfg_nlines), .cfg_int(cfg_int),
    .cfg_ndr_en(cfg_ndr_en), .cfg_ndr_md(cfg_ndr_md),
    .cfg_wpos(cfg_wpos), .cfg_dly(cfg_dly),
    .rst_row(rst_row), .rst_stb(rst_stb), .rd_row(rd_row), .rd_stb(rd_stb),
    .eol(eol), .eof(eof), .pix_vld(pix_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // expected start row: dummies and the extra pair first, then 24-row blocks
  function automatic int exp_base(input int pos);
    int p;
    p = (pos < 137) ? pos : 137;
    if (p >= 13) return 14 + (p - 13) * 24;
    return p;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_line();
    @(negedge clk) line_adv = 1'b1;
    @(negedge clk) line_adv = 1'b0;
    @(negedge clk);
    s_rd_stb = rd_stb; s_rd_row = rd_row;
    s_rst_stb = rst_stb; s_rst_row = rst_row;
    k_eol = -1; k_eof = -1; k_pix = -1;
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      if (eol && k_eol < 0) k_eol = k;
      if (eof && k_eof < 0) k_eof = k;
      if (pix_vld && k_pix < 0) k_pix = k;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    do_reset();
    @(negedge clk);
    chk({rd_stb, rst_stb, eol, eof, pix_vld} == 5'b0, "R10 reset outputs",
        int'({rd_stb, rst_stb, eol, eof, pix_vld}), 0);

    // R6: window start mapping, observed on line 0
    begin
      int plist[10] = '{0, 5, 11, 12, 13, 14, 50, 136, 137, 255};
      foreach (plist[i]) begin
        cfg_nlines = 12'd2; cfg_int = 12'd0; cfg_ndr_en = 0; cfg_dly = 8'h00;
        cfg_wpos = 8'(plist[i]);
        do_reset();
        run_line();
        chk(s_rd_stb == 1 && s_rd_row == exp_base(plist[i]), "R6 window start row",
            s_rd_row, exp_base(plist[i]));
      end
    end

    // R7: mid-frame changes wait for the next frame
    cfg_nlines = 12'd3; cfg_int = 12'd1; cfg_ndr_en = 0; cfg_wpos = 8'd2; cfg_dly = 8'h00;
    do_reset();
    run_line();
    run_line();
    cfg_nlines = 12'd5; cfg_int = 12'd3; cfg_wpos = 8'd13; cfg_dly = 8'h55;
    run_line();
    chk(s_rd_row == 4, "R7 read row held", s_rd_row, 4);
    chk(s_rst_row == 3, "R7 reset row held", s_rst_row, 3);
    chk(k_eol == 0, "R7 delay held", k_eol, 0);
    run_line();
    chk(k_eof == 0, "R7 frame end held", k_eof, 0);
    run_line();
    chk(s_rd_row == 14, "R7 new base applied", s_rd_row, 14);
    chk(k_eol == 5 && k_eof == -1, "R7 new delay applied", k_eol, 5);
    chk(s_rst_row == 14 + 3, "R7 new integration applied", s_rst_row, 17);

    // sweep: lines, integration, mode
    for (int nn = 0; nn <= 4; nn++) begin
      for (int tt = 0; tt <= 6; tt++) begin
        for (int md = 0; md <= 2; md++) begin
          int base, tc, dpv, deo, absl, ph, kk;
          tc  = (tt > nn) ? nn : tt;
          dpv = (nn + 2 * tt + md) % 16;
          deo = (3 * nn + tt + 2 * md) % 16;
          cfg_nlines = 12'(nn);
          cfg_int    = 12'(tt);
          cfg_ndr_en = (md != 0);
          cfg_ndr_md = (md == 2);
          cfg_wpos   = 8'((nn * 5 + tt * 3 + md) % 40);
          cfg_dly    = 8'(deo * 16 + dpv);
          base = exp_base((nn * 5 + tt * 3 + md) % 40);
          kk   = 2 * tc + 1;
          for (int r = 0; r < 8; r++) begin
            last_rst[r] = -1; last_rd[r] = -1; prev_iv[r] = -1;
          end
          do_reset();
          absl = 0;
          ph = 0;
          for (int f = 0; f < 4; f++) begin
            for (int ll = 0; ll <= nn; ll++) begin
              run_line();
              chk(k_eol == deo, "R8 end-of-line delay", k_eol, deo);
              chk(k_eof == ((ll == nn) ? deo : -1), "R8 end-of-frame pulse",
                  k_eof, (ll == nn) ? deo : -1);
              chk(k_pix == dpv, "R9 pixel-valid delay", k_pix, dpv);
              if (md == 0) begin
                int r, rr;
                chk(s_rd_stb == 1 && s_rd_row == base + ll, "R1 read pointer step",
                    s_rd_row, base + ll);
                chk(s_rst_stb == 1, "R2 reset every line", s_rst_stb, 1);
                r = s_rd_row - base;
                if (r >= 0 && r <= nn && last_rst[r] >= 0)
                  chk(absl - last_rst[r] == nn - tc + 1,
                      (tt > nn) ? "R3 clamped exposure" : "R2 exposure lines",
                      absl - last_rst[r], nn - tc + 1);
                rr = s_rst_row - base;
                chk(rr >= 0 && rr <= nn, "R2 reset row in window", rr, 0);
                if (rr >= 0 && rr <= nn) last_rst[rr] = absl;
              end else if (md == 1) begin
                int r;
                chk(s_rd_stb == 1 && s_rd_row == base + ll, "R1 read pointer step",
                    s_rd_row, base + ll);
                r = s_rd_row - base;
                if (r >= 0 && r <= nn) begin
                  if (last_rd[r] >= 0)
                    chk(absl - last_rd[r] == nn + 1, "R4 read spacing",
                        absl - last_rd[r], nn + 1);
                  last_rd[r] = absl;
                end
                chk(s_rst_stb == (ph == 0), "R4 reset only in even frames",
                    s_rst_stb, (ph == 0));
              end else begin
                chk(s_rd_stb == (ph == 0), "R5 leading read only in even frames",
                    s_rd_stb, (ph == 0));
                for (int w = 0; w < 2; w++) begin
                  int st, r, iv;
                  st = (w == 0) ? s_rd_stb : s_rst_stb;
                  r  = ((w == 0) ? s_rd_row : s_rst_row) - base;
                  if (st) begin
                    chk(r >= 0 && r <= nn, "R5 read row in window", r, 0);
                    if (r >= 0 && r <= nn) begin
                      if (last_rd[r] >= 0) begin
                        iv = absl - last_rd[r];
                        chk(iv == kk || iv == 2 * (nn + 1) - kk, "R5 read spacing", iv, kk);
                        if (prev_iv[r] >= 0 && kk != 2 * (nn + 1) - kk)
                          chk(iv != prev_iv[r], "R5 spacing alternates", iv, prev_iv[r]);
                        prev_iv[r] = iv;
                      end
                      last_rd[r] = absl;
                    end
                  end
                end
              end
              absl++;
            end
            ph = 1 - ph;
          end
          if (md == 2) begin
            for (int r = 0; r <= nn; r++)
              chk(prev_iv[r] >= 0, "R5 every row read twice per cycle", prev_iv[r], 1);
          end
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule